// File: doc/BRIEF.md
# UART Receive Character Queue

This block sits between the receive shifter of an asynchronous serial channel and the CPU. Each assembled character arrives with three flags: parity error, framing error and break. In multidrop mode the parity-error flag carries the address/data bit instead. The character and its flags are stored together in a queue. The usable depth of the queue is set by a mode input to 8 or 16 entries. The CPU side sees the head character, a status view, a fill-level interrupt, an idle-data watchdog interrupt and a request-to-send output for flow control.

A character that arrives while the queue is full is parked in a single holding stage. It drops into the queue as soon as a position frees. If another start bit is signalled while a character is parked and the queue is still full, the parked character is lost and the sticky overrun flag is set.

The status view has two modes. It can show the flags of the head character alone. It can also show the accumulated OR of the flags of every character that has reached the head since the last error-reset command.

Top module: `rxq_buffer`

## Requirements
- R1: After `rst`, and one cycle after a `cmd_rx_reset` pulse, the queue is empty: `rd_ready`=0, `rd_full`=0, the three status outputs are 0 and `irq_wdog`=0. After `rst`, `rts_on`=1 and `st_overrun`=0. A receiver reset does not clear `st_overrun`.
- R2: Characters leave the queue in arrival order. `rd_full` is 1 when the fill count reaches the selected depth: 8 when `cfg_deep`=0, 16 when `cfg_deep`=1. `rd_data` shows the head character whenever `rd_ready`=1.
- R3: The fill count never exceeds the selected depth. A character accepted while the queue is full is held, and it enters the queue in the cycle after a pop frees a position.
- R4: A `start_seen` pulse while a character is held and the queue is full discards the held character and sets `st_overrun`. The queued contents are unchanged. `st_overrun` stays set until a `cmd_err_reset` pulse.
- R5: With `cfg_block`=0, {`st_brk`,`st_ferr`,`st_perr`} equals the flags of the head entry, or 0 when the queue is empty.
- R6: With `cfg_block`=1, the status outputs show the OR of the flags of the current head and of every entry popped since the last `cmd_err_reset` or receiver reset. The value remains after the queue drains.
- R7: The head character and the fill count change only through `rd_pop`, through a character being written, or through a receiver reset. Status outputs are continuous and never consume an entry.
- R8: `irq_level` is 1 when the fill count is at least the threshold chosen by `cfg_level`. The codes are: 0 = one entry, 1 = half the selected depth, 2 = three quarters of it, 3 = the full depth.
- R9: With `cfg_wdog_en`=1 and the queue non-empty, `irq_wdog` rises after the 64th `bit_tick` strobe with no write and no pop. Any write or pop restarts the count and clears the interrupt. An empty queue keeps it at 0.
- R10: With `cfg_autorts`=1, a `start_seen` pulse while the queue is full drives `rts_on` to 0 on the next cycle. `rts_on` returns to 1 in the cycle after the fill count drops below the depth. With `cfg_autorts`=0, `rts_on` stays 1.
- R11: With `rx_enable`=0 and `cfg_multidrop`=1, only characters with `chr_perr`=1 (address characters) are stored. That bit is reported in the `st_perr` position.
- R12: With `rx_enable`=0 and `cfg_multidrop`=0, incoming characters are ignored. Entries already queued stay readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_deep | input | 1 | 0: 8-entry depth, 1: 16-entry depth |
| cfg_block | input | 1 | 0: head status, 1: accumulated status |
| cfg_level | input | 2 | Fill-level interrupt threshold code |
| cfg_wdog_en | input | 1 | Enables the idle-data watchdog |
| cfg_autorts | input | 1 | Enables automatic request-to-send control |
| cfg_multidrop | input | 1 | Enables address filtering while disabled |
| rx_enable | input | 1 | Receiver enable |
| cmd_rx_reset | input | 1 | Receiver reset pulse |
| cmd_err_reset | input | 1 | Error reset pulse |
| start_seen | input | 1 | Valid start bit signalled by the shifter |
| chr_valid | input | 1 | Assembled character strobe |
| chr_data | input | 8 | Assembled character |
| chr_perr | input | 1 | Parity error or address/data bit |
| chr_ferr | input | 1 | Framing error flag |
| chr_brk | input | 1 | Break flag |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| rd_pop | input | 1 | Data read, pops the head entry |
| rd_data | output | 8 | Head character, 0 when empty |
| rd_ready | output | 1 | Queue not empty |
| rd_full | output | 1 | Queue holds the selected depth |
| st_perr | output | 1 | Parity error / address status |
| st_ferr | output | 1 | Framing error status |
| st_brk | output | 1 | Break status |
| st_overrun | output | 1 | Sticky overrun flag |
| irq_level | output | 1 | Fill-level interrupt |
| irq_wdog | output | 1 | Idle-data watchdog interrupt |
| rts_on | output | 1 | Request-to-send asserted |

## Verification
The overrun path is the hardest state to reach. It needs a full queue, a parked character and then a bare start pulse, all with no pop in between. Random traffic rarely keeps the reader idle that long. Directed sequences fill the queue to the selected depth, park one more character and issue a lone start strobe. The queue is then drained entry by entry to show that only the parked character was lost. The 64-tick watchdog window is reached in the same way, by a run of ticks with the port held quiet.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } rxq_stat_t;

    typedef struct packed {
        rxq_stat_t          stat;
        logic [DATA_W-1:0]  data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        LVL_ONE  = 2'd0,
        LVL_HALF = 2'd1,
        LVL_3Q   = 2'd2,
        LVL_FULL = 2'd3
    } rxq_level_e;

    function automatic int level_target(input logic [1:0] code, input int depth);
        case (rxq_level_e'(code))
            LVL_ONE:  return 1;
            LVL_HALF: return depth / 2;
            LVL_3Q:   return (depth * 3) / 4;
            default:  return depth;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int MAX_DEPTH     = 16,
    parameter int SHALLOW_DEPTH = 8,
    localparam int PW = $clog2(MAX_DEPTH),
    localparam int CW = $clog2(MAX_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          deep,
    input  logic          accept,
    input  logic          start_seen,
    input  rxq_entry_t    in_word,
    input  logic          pop_req,
    input  logic          rx_reset,
    input  logic          err_reset,
    output rxq_entry_t    head,
    output logic [CW-1:0] fill,
    output logic          full,
    output logic          wr_en,
    output logic          pop_en,
    output logic          overrun,
    output logic          hold_v
);

    rxq_entry_t    mem [MAX_DEPTH];
    rxq_entry_t    hold_q;
    rxq_entry_t    wr_word;
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic [CW-1:0] depth_sel;
    logic          ovr_set;

    assign depth_sel = deep ? CW'(MAX_DEPTH) : CW'(SHALLOW_DEPTH);
    assign full      = (fill >= depth_sel);
    assign pop_en    = pop_req && (fill != '0) && !rx_reset;
    assign wr_en     = !rx_reset && !full && (hold_v || accept);
    assign wr_word   = hold_v ? hold_q : in_word;
    assign ovr_set   = !rx_reset && full && hold_v && (accept || start_seen);
    assign head      = mem[rptr];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst || rx_reset) begin
            wptr   <= '0;
            rptr   <= '0;
            fill   <= '0;
            hold_v <= 1'b0;
            hold_q <= '0;
        end else begin
            if (wr_en)  wptr <= wptr + PW'(1);
            if (pop_en) rptr <= rptr + PW'(1);
            fill <= fill + CW'(wr_en) - CW'(pop_en);
            if (hold_v) begin
                if (!full) begin
                    hold_v <= accept;
                    hold_q <= in_word;
                end else if (accept) begin
                    hold_q <= in_word;
                end else if (start_seen) begin
                    hold_v <= 1'b0;
                end
            end else if (accept && full) begin
                hold_v <= 1'b1;
                hold_q <= in_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || err_reset) overrun <= 1'b0;
        else if (ovr_set)     overrun <= 1'b1;
    end

endmodule

// File: rtl/rxq_watchdog.sv
module rxq_watchdog #(
    parameter int TICKS = 64,
    localparam int NW = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic nonempty,
    input  logic restart,
    input  logic bit_tick,
    output logic irq
);

    logic [NW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable || !nonempty || restart) begin
            cnt <= '0;
            irq <= 1'b0;
        end else if (bit_tick && !irq) begin
            cnt <= cnt + NW'(1);
            if (cnt == NW'(TICKS - 1)) irq <= 1'b1;
        end
    end

endmodule

// File: rtl/rxq_report.sv
module rxq_report
    import rxq_pkg::*;
#(
    parameter int MAX_DEPTH     = 16,
    parameter int SHALLOW_DEPTH = 8,
    localparam int CW = $clog2(MAX_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          deep,
    input  logic          block_mode,
    input  logic [1:0]    level_code,
    input  logic          autorts,
    input  logic          start_seen,
    input  logic          rx_reset,
    input  logic          err_reset,
    input  logic          pop_en,
    input  rxq_stat_t     head_stat,
    input  logic [CW-1:0] fill,
    input  logic          full,
    output rxq_stat_t     stat,
    output logic          irq_level,
    output logic          rts_on
);

    rxq_stat_t     acc;
    logic [CW-1:0] target;

    always_ff @(posedge clk) begin
        if (rst || rx_reset || err_reset) acc <= '0;
        else if (pop_en)                  acc <= acc | head_stat;
    end

    assign stat = block_mode ? (acc | head_stat) : head_stat;

    assign target    = deep ? CW'(level_target(level_code, MAX_DEPTH))
                            : CW'(level_target(level_code, SHALLOW_DEPTH));
    assign irq_level = (fill >= target);

    always_ff @(posedge clk) begin
        if (rst || !autorts)         rts_on <= 1'b1;
        else if (start_seen && full) rts_on <= 1'b0;
        else if (!full)              rts_on <= 1'b1;
    end

endmodule

// File: rtl/rxq_buffer.sv
module rxq_buffer
    import rxq_pkg::*;
#(
    parameter int MAX_DEPTH     = 16,
    parameter int SHALLOW_DEPTH = 8,
    parameter int WDOG_TICKS    = 64,
    localparam int CW = $clog2(MAX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_deep,
    input  logic              cfg_block,
    input  logic [1:0]        cfg_level,
    input  logic              cfg_wdog_en,
    input  logic              cfg_autorts,
    input  logic              cfg_multidrop,
    input  logic              rx_enable,
    input  logic              cmd_rx_reset,
    input  logic              cmd_err_reset,
    input  logic              start_seen,
    input  logic              chr_valid,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_perr,
    input  logic              chr_ferr,
    input  logic              chr_brk,
    input  logic              bit_tick,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ready,
    output logic              rd_full,
    output logic              st_perr,
    output logic              st_ferr,
    output logic              st_brk,
    output logic              st_overrun,
    output logic              irq_level,
    output logic              irq_wdog,
    output logic              rts_on
);

    rxq_entry_t    in_word;
    rxq_entry_t    head;
    rxq_stat_t     head_stat;
    rxq_stat_t     stat;
    logic [CW-1:0] fill;
    logic          full;
    logic          wr_en;
    logic          pop_en;
    logic          hold_v;
    logic          accept;

    assign accept  = chr_valid && (rx_enable || (cfg_multidrop && chr_perr));
    assign in_word = '{stat: '{brk: chr_brk, ferr: chr_ferr, perr: chr_perr},
                       data: chr_data};

    rxq_store #(
        .MAX_DEPTH(MAX_DEPTH), .SHALLOW_DEPTH(SHALLOW_DEPTH)
    ) u_store (
        .clk(clk), .rst(rst), .deep(cfg_deep), .accept(accept),
        .start_seen(start_seen), .in_word(in_word), .pop_req(rd_pop),
        .rx_reset(cmd_rx_reset), .err_reset(cmd_err_reset), .head(head),
        .fill(fill), .full(full), .wr_en(wr_en), .pop_en(pop_en),
        .overrun(st_overrun), .hold_v(hold_v)
    );

    assign rd_ready  = (fill != '0);
    assign rd_full   = full;
    assign rd_data   = rd_ready ? head.data : '0;
    assign head_stat = rd_ready ? head.stat : '0;

    rxq_report #(
        .MAX_DEPTH(MAX_DEPTH), .SHALLOW_DEPTH(SHALLOW_DEPTH)
    ) u_report (
        .clk(clk), .rst(rst), .deep(cfg_deep), .block_mode(cfg_block),
        .level_code(cfg_level), .autorts(cfg_autorts), .start_seen(start_seen),
        .rx_reset(cmd_rx_reset), .err_reset(cmd_err_reset), .pop_en(pop_en),
        .head_stat(head_stat), .fill(fill), .full(full), .stat(stat),
        .irq_level(irq_level), .rts_on(rts_on)
    );

    assign st_perr = stat.perr;
    assign st_ferr = stat.ferr;
    assign st_brk  = stat.brk;

    rxq_watchdog #(
        .TICKS(WDOG_TICKS)
    ) u_wdog (
        .clk(clk), .rst(rst), .enable(cfg_wdog_en), .nonempty(rd_ready),
        .restart(wr_en || pop_en || cmd_rx_reset), .bit_tick(bit_tick),
        .irq(irq_wdog)
    );

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int MAX_DEPTH     = 16,
    parameter int SHALLOW_DEPTH = 8,
    localparam int CW = $clog2(MAX_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_deep,
    input logic          cfg_autorts,
    input logic          cmd_rx_reset,
    input logic          cmd_err_reset,
    input logic          start_seen,
    input logic          chr_valid,
    input logic          rd_pop,
    input logic [7:0]    rd_data,
    input logic          rd_ready,
    input logic          rd_full,
    input logic          st_overrun,
    input logic          irq_wdog,
    input logic          rts_on,
    input logic [CW-1:0] fill,
    input logic          hold_v
);

    logic [CW-1:0] limit;
    assign limit = cfg_deep ? CW'(MAX_DEPTH) : CW'(SHALLOW_DEPTH);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        fill <= limit);

    assert_pop_only_R7: assert property (@(posedge clk) disable iff (rst)
        (!rd_pop && !chr_valid && !hold_v && !cmd_rx_reset)
        |=> ($stable(fill) && $stable(rd_data)));

    assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (st_overrun && !cmd_err_reset) |=> st_overrun);

    assert_rts_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_autorts && start_seen && rd_full) |=> !rts_on);

    assert_wdog_data_R9: assert property (@(posedge clk) disable iff (rst)
        irq_wdog |-> rd_ready);

    assert_rx_reset_R1: assert property (@(posedge clk) disable iff (rst)
        cmd_rx_reset |=> (!rd_ready && !rd_full && !irq_wdog));

endmodule

bind rxq_buffer rxq_checker #(
    .MAX_DEPTH(MAX_DEPTH), .SHALLOW_DEPTH(SHALLOW_DEPTH)
) u_chk (
    .clk(clk), .rst(rst), .cfg_deep(cfg_deep), .cfg_autorts(cfg_autorts),
    .cmd_rx_reset(cmd_rx_reset), .cmd_err_reset(cmd_err_reset),
    .start_seen(start_seen), .chr_valid(chr_valid), .rd_pop(rd_pop),
    .rd_data(rd_data), .rd_ready(rd_ready), .rd_full(rd_full),
    .st_overrun(st_overrun), .irq_wdog(irq_wdog), .rts_on(rts_on),
    .fill(fill), .hold_v(hold_v)
);

// File: tb/rxq_buffer_test.sv
`timescale 1ns/1ps
module rxq_buffer_test;

    logic clk = 1'b0;
    logic rst;
    logic cfg_deep, cfg_block, cfg_wdog_en, cfg_autorts, cfg_multidrop, rx_enable;
    logic [1:0] cfg_level;
    logic cmd_rx_reset, cmd_err_reset, start_seen, chr_valid;
    logic [7:0] chr_data;
    logic chr_perr, chr_ferr, chr_brk, bit_tick, rd_pop;
    logic [7:0] rd_data;
    logic rd_ready, rd_full, st_perr, st_ferr, st_brk, st_overrun;
    logic irq_level, irq_wdog, rts_on;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    rxq_buffer uut (
        .clk(clk), .rst(rst), .cfg_deep(cfg_deep), .cfg_block(cfg_block),
        .cfg_level(cfg_level), .cfg_wdog_en(cfg_wdog_en), .cfg_autorts(cfg_autorts),
        .cfg_multidrop(cfg_multidrop), .rx_enable(rx_enable),
        .cmd_rx_reset(cmd_rx_reset), .cmd_err_reset(cmd_err_reset),
        .start_seen(start_seen), .chr_valid(chr_valid), .chr_data(chr_data),
        .chr_perr(chr_perr), .chr_ferr(chr_ferr), .chr_brk(chr_brk),
        .bit_tick(bit_tick), .rd_pop(rd_pop), .rd_data(rd_data),
        .rd_ready(rd_ready), .rd_full(rd_full), .st_perr(st_perr),
        .st_ferr(st_ferr), .st_brk(st_brk), .st_overrun(st_overrun),
        .irq_level(irq_level), .irq_wdog(irq_wdog), .rts_on(rts_on)
    );

    // reference model state; word = {brk, ferr, perr, data}
    logic [10:0] mq[$];
    bit          mhv;
    logic [10:0] mhold;
    bit          movr;
    logic [2:0]  mbacc;
    int          mwcnt;
    bit          mwirq;
    bit          mrts;

    function automatic int thr(input logic [1:0] code, input int d);
        if (code == 2'd0) return 1;
        if (code == 2'd1) return d / 2;
        if (code == 2'd2) return (3 * d) / 4;
        return d;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        int d, sz;
        bit full, acc, pop, push, oset;
        logic [10:0] w;
        if (rst) begin
            mq.delete(); mhv = 0; movr = 0; mbacc = 0;
            mwcnt = 0; mwirq = 0; mrts = 1;
            return;
        end
        d    = cfg_deep ? 16 : 8;
        sz   = mq.size();
        full = (sz >= d);
        acc  = chr_valid && (rx_enable || (cfg_multidrop && chr_perr));
        w    = {chr_brk, chr_ferr, chr_perr, chr_data};
        if (!cfg_autorts)            mrts = 1;
        else if (start_seen && full) mrts = 0;
        else if (!full)              mrts = 1;
        if (cmd_rx_reset) begin
            mq.delete(); mhv = 0; mbacc = 0; mwcnt = 0; mwirq = 0;
            if (cmd_err_reset) movr = 0;
            return;
        end
        pop = rd_pop && (sz > 0);
        push = 0; oset = 0;
        if (pop) begin
            mbacc = mbacc | mq[0][10:8];
            void'(mq.pop_front());
        end
        if (mhv) begin
            if (!full) begin
                mq.push_back(mhold); push = 1; mhv = acc; mhold = w;
            end else if (acc) begin
                mhold = w; oset = 1;
            end else if (start_seen) begin
                mhv = 0; oset = 1;
            end
        end else if (acc) begin
            if (!full) begin mq.push_back(w); push = 1; end
            else begin mhv = 1; mhold = w; end
        end
        if (cmd_err_reset) begin movr = 0; mbacc = 0; end
        else if (oset) movr = 1;
        if (!cfg_wdog_en || sz == 0 || push || pop) begin
            mwcnt = 0; mwirq = 0;
        end else if (bit_tick && !mwirq) begin
            mwcnt++;
            if (mwcnt == 64) mwirq = 1;
        end
    endtask

    task automatic compare();
        int d, sz;
        logic [2:0] head, est;
        d    = cfg_deep ? 16 : 8;
        sz   = mq.size();
        head = (sz > 0) ? mq[0][10:8] : 3'b000;
        est  = cfg_block ? (mbacc | head) : head;
        chk("R2 ready", rd_ready, sz > 0);
        chk("R2 full", rd_full, sz >= d);
        chk("R2 data", rd_data, (sz > 0) ? mq[0][7:0] : 0);
        chk(cfg_block ? "R6 status" : "R5 status", {st_brk, st_ferr, st_perr}, est);
        chk("R4 overrun", st_overrun, movr);
        chk("R8 level irq", irq_level, sz >= thr(cfg_level, d));
        chk("R9 watchdog irq", irq_wdog, mwirq);
        chk("R10 rts", rts_on, mrts);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic put(input logic [7:0] dv, input logic p, input logic f, input logic b);
        start_seen = 1; cyc(); start_seen = 0;
        chr_valid = 1; chr_data = dv; chr_perr = p; chr_ferr = f; chr_brk = b;
        cyc();
        chr_valid = 0; chr_perr = 0; chr_ferr = 0; chr_brk = 0;
    endtask

    task automatic take();
        rd_pop = 1; cyc(); rd_pop = 0;
    endtask

    task automatic drain();
        while (mq.size() > 0 || mhv) take();
    endtask

    task automatic pulse_err();
        cmd_err_reset = 1; cyc(); cmd_err_reset = 0;
    endtask

    task automatic tick();
        bit_tick = 1; cyc(); bit_tick = 0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_deep = 0; cfg_block = 0; cfg_level = 0; cfg_wdog_en = 0;
        cfg_autorts = 0; cfg_multidrop = 0; rx_enable = 1; cmd_rx_reset = 0;
        cmd_err_reset = 0; start_seen = 0; chr_valid = 0; chr_data = 0;
        chr_perr = 0; chr_ferr = 0; chr_brk = 0; bit_tick = 0; rd_pop = 0;
        void'($urandom(32'h5eed_1234));
        idle(3);
        rst = 0;
        cyc();
        // R1 reset state
        chk("R1 ready after reset", rd_ready, 0);
        chk("R1 rts after reset", rts_on, 1);
        chk("R1 overrun after reset", st_overrun, 0);

        // R2 / R3: depth 8, hold stage
        for (int i = 0; i < 8; i++) put(8'(i + 1), 0, 0, 0);
        chk("R2 full at 8", rd_full, 1);
        put(8'h99, 0, 0, 0);
        chk("R3 still full with held char", rd_full, 1);
        chk("R3 head unchanged", rd_data, 1);
        take();
        cyc();
        chk("R3 held char entered", rd_full, 1);
        for (int i = 0; i < 7; i++) take();
        chk("R3 held char last", rd_data, 8'h99);
        take();
        chk("R2 empty after drain", rd_ready, 0);

        // R4 overrun
        for (int i = 0; i < 8; i++) put(8'(8'h20 + i), 0, 0, 0);
        put(8'hAA, 0, 0, 0);
        start_seen = 1; cyc(); start_seen = 0;
        chk("R4 overrun set", st_overrun, 1);
        for (int i = 0; i < 8; i++) begin
            chk("R4 contents unchanged", rd_data, 8'h20 + i);
            take();
        end
        chk("R4 held char lost", rd_ready, 0);
        pulse_err();
        chk("R4 overrun cleared", st_overrun, 0);

        // R5 head status
        put(8'h01, 1, 0, 0); put(8'h02, 0, 1, 0); put(8'h03, 0, 0, 1);
        chk("R5 head perr", {st_brk, st_ferr, st_perr}, 3'b001);
        take();
        chk("R5 head ferr", {st_brk, st_ferr, st_perr}, 3'b010);
        take();
        chk("R5 head brk", {st_brk, st_ferr, st_perr}, 3'b100);
        take();

        // R6 accumulated status
        cfg_block = 1; pulse_err();
        put(8'h01, 1, 0, 0); put(8'h02, 0, 1, 0); put(8'h03, 0, 0, 1);
        chk("R6 first", {st_brk, st_ferr, st_perr}, 3'b001);
        take();
        chk("R6 two", {st_brk, st_ferr, st_perr}, 3'b011);
        take(); take();
        chk("R6 sticky after drain", {st_brk, st_ferr, st_perr}, 3'b111);
        pulse_err();
        chk("R6 cleared by error reset", {st_brk, st_ferr, st_perr}, 3'b000);
        cfg_block = 0;

        // R7 status never pops
        put(8'h41, 0, 1, 0); put(8'h42, 0, 0, 0);
        idle(20);
        chk("R7 head stable", rd_data, 8'h41);
        chk("R7 status stable", st_ferr, 1);
        drain();

        // R8 thresholds
        cfg_deep = 1; cfg_level = 2;
        for (int i = 0; i < 11; i++) put(8'(i), 0, 0, 0);
        chk("R8 below 3/4 of 16", irq_level, 0);
        put(8'h0B, 0, 0, 0);
        chk("R8 at 3/4 of 16", irq_level, 1);
        cfg_level = 3; cyc();
        chk("R8 full code not met", irq_level, 0);
        for (int i = 0; i < 4; i++) put(8'(i), 0, 0, 0);
        chk("R8 full code met", irq_level, 1);
        chk("R2 full at 16", rd_full, 1);
        drain();
        cfg_deep = 0; cfg_level = 1;
        for (int i = 0; i < 3; i++) put(8'(i), 0, 0, 0);
        chk("R8 below half of 8", irq_level, 0);
        put(8'h03, 0, 0, 0);
        chk("R8 at half of 8", irq_level, 1);
        drain();
        cfg_level = 0;

        // R9 watchdog
        cfg_wdog_en = 1;
        for (int i = 0; i < 70; i++) tick();
        chk("R9 empty no irq", irq_wdog, 0);
        put(8'h5A, 0, 0, 0);
        for (int i = 0; i < 63; i++) tick();
        chk("R9 63 ticks", irq_wdog, 0);
        tick();
        chk("R9 64 ticks", irq_wdog, 1);
        take();
        chk("R9 cleared by read", irq_wdog, 0);
        cfg_wdog_en = 0;

        // R10 auto RTS
        cfg_autorts = 1; cyc();
        for (int i = 0; i < 8; i++) put(8'(i), 0, 0, 0);
        chk("R10 rts on while filling", rts_on, 1);
        start_seen = 1; cyc(); start_seen = 0;
        chk("R10 rts dropped", rts_on, 0);
        take();
        chk("R10 rts still low at pop edge", rts_on, 0);
        cyc();
        chk("R10 rts restored", rts_on, 1);
        drain();
        cfg_autorts = 0;

        // R11 multidrop filter
        rx_enable = 0; cfg_multidrop = 1;
        put(8'h55, 0, 0, 0); put(8'h66, 1, 0, 0);
        chk("R11 address stored", rd_data, 8'h66);
        chk("R11 address bit in perr", st_perr, 1);
        take();
        chk("R11 data char discarded", rd_ready, 0);

        // R12 disabled ignores
        cfg_multidrop = 0;
        put(8'h77, 1, 0, 0);
        chk("R12 ignored while disabled", rd_ready, 0);
        rx_enable = 1; put(8'h12, 0, 0, 0); rx_enable = 0; idle(2);
        chk("R12 readable while disabled", rd_data, 8'h12);
        take();
        rx_enable = 1;

        // R1 receiver reset
        put(8'h31, 1, 1, 0); put(8'h32, 0, 0, 0);
        cmd_rx_reset = 1; cyc(); cmd_rx_reset = 0;
        chk("R1 rx reset empties", rd_ready, 0);
        chk("R1 rx reset status", {st_brk, st_ferr, st_perr}, 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            start_seen    = ($urandom % 4) == 0;
            chr_valid     = ($urandom % 4) == 0;
            chr_data      = 8'($urandom);
            chr_perr      = ($urandom % 3) == 0;
            chr_ferr      = ($urandom % 5) == 0;
            chr_brk       = ($urandom % 7) == 0;
            rd_pop        = ($urandom % 5) == 0;
            bit_tick      = ($urandom % 2) == 0;
            cmd_err_reset = ($urandom % 64) == 0;
            cmd_rx_reset  = ($urandom % 300) == 0;
            if (($urandom % 50) == 0) begin
                rx_enable     = ($urandom % 4) != 0;
                cfg_multidrop = ($urandom % 3) == 0;
                cfg_block     = 1'($urandom);
                cfg_level     = 2'($urandom);
                cfg_autorts   = 1'($urandom);
                cfg_wdog_en   = 1'($urandom);
            end
            if (mq.size() == 0 && !mhv && ($urandom % 20) == 0)
                cfg_deep = 1'($urandom);
            cyc();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule